// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked front end of a 32-bit synchronous burst static RAM, with a small behavioural storage array inside. On each rising clock edge it samples three chip enables, two competing cycle-start strobes, a burst advance strobe and the write controls. From these it decides whether a new access starts, whether a running burst moves to the next address or repeats the current one, and whether the beat is a read or a write.

A processor-side strobe always opens a read. A controller-side strobe opens a read or a write, as the write controls on that edge decide. Byte-lane enables pick which 8-bit lanes a write changes, and a global-write input forces all four lanes. Burst addresses wrap inside a group of four words, in either an interleaved (XOR) order or a linear order.

Read data can leave the block flow-through or one clock later through an output register. An asynchronous output enable gates the data driver. A static strap selects whether output survives for one more cycle when enables 2/3 deselect the device in the middle of a burst read. Another strap sets the burst order and a third sets the output mode. All straps are held constant between resets.

Top module: `sburst_sram`

## Requirements
- R1: A start is either a processor-side strobe with `cs1_n` low or any controller-side strobe. A start selects the device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0, and any other combination deselects it. On edges without a start, `cs2` and `cs3_n` have no effect.
- R2: A low `ads_cpu_n` is ignored while `cs1_n` is high. A low `ads_ctl_n` while `cs1_n` is high deselects the device, and no read beat is presented after that edge.
- R3: A selected start through `ads_cpu_n` is a read of `addr`, whatever the write controls are. A write to the current address follows on a later edge that has both strobes high, `adv_n` high and active write controls. A write beat never drives data.
- R4: A selected start through `ads_ctl_n` alone reads or writes `addr`, following the write controls sampled on that edge.
- R5: On an edge with both strobes high and the device selected, `adv_n`=0 steps the burst count (modulo 4) and `adv_n`=1 keeps it. The two low address bits are start XOR count when `interleave`=1, and (start + count) mod 4 when `interleave`=0. The upper address bits stay fixed.
- R6: With `gw_n`=0, all four lanes are written. With `gw_n`=1 and `bwe_n`=1, the beat is a read. With `gw_n`=1 and `bwe_n`=0, lane i (data bits 8i+7..8i) is written when `bw_n[i]`=0, and `bw_n`=4'b1111 makes the beat a read.
- R7: With `pipe_mode`=0, the data of a read beat accepted on edge k is on `dq_o` during the cycle after edge k. With `pipe_mode`=1, it appears one cycle later, after edge k+1.
- R8: With `pipe_mode`=1, a write accepted on edge k takes its data and its lane mask from the inputs sampled on edge k+1. With `pipe_mode`=0, both come from edge k.
- R9: `dq_en` is high exactly when `oe_n` is low and a read beat is being presented, and it follows `oe_n` without waiting for a clock edge.
- R10: When a start with `cs1_n` low deselects the device through `cs2`/`cs3_n` during a burst read, and `hold_mode`=1, the beat that would follow that edge is still presented for one cycle. In flow-through mode this is the beat shown just before the edge, and in pipelined mode it is the beat already in the output register. With `hold_mode`=0, or on a deselect caused by `cs1_n` high, the output drops at that edge.
- R11: A deselected device ignores `adv_n` and the write controls, and presents no beat until a selecting start.
- R12: After reset the device is deselected, with no pending write and no beat presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static strap: 1 registered output, 0 flow-through |
| interleave | input | 1 | Static strap: 1 XOR burst order, 0 linear |
| hold_mode | input | 1 | Static strap: 1 keeps one beat on deselect by enables 2/3 |
| cs1_n | input | 1 | Chip enable 1, active low |
| cs2 | input | 1 | Chip enable 2, active high, sampled on starts |
| cs3_n | input | 1 | Chip enable 3, active low, sampled on starts |
| ads_cpu_n | input | 1 | Processor-side start strobe, active low |
| ads_ctl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| wdata | input | 8*LANES | Write data |
| dq_o | output | 8*LANES | Read data toward the pad driver |
| dq_en | output | 1 | Pad driver enable; the bus is high-impedance when low |

## Verification
On every cycle the assertions check these behaviours:
- the output-enable gate;
- the blanking of output after a controller-side strobe with `cs1_n` high, and that it stays blank while no new start follows;
- the quiet data bus on a controller-started global write in flow-through mode;
- the immediate read beat after a selected processor-side start.

Several behaviours depend on the contents of the storage, so only the bench scenarios can show them: the burst address orders, lane merging, late write lanes in pipelined mode, the one-cycle output shift between modes and the extra hold beat. A reference model in the bench follows random strobe mixes under all eight strap combinations.

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pipe_mode,
  input  logic               interleave,
  input  logic               hold_mode,
  input  logic               cs1_n,
  input  logic               cs2,
  input  logic               cs3_n,
  input  logic               ads_cpu_n,
  input  logic               ads_ctl_n,
  input  logic               adv_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [LANES-1:0]   bw_n,
  input  logic               oe_n,
  input  logic [AW-1:0]      addr,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] dq_o,
  output logic               dq_en
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          act, rd, ov, wp;
  logic [AW-1:0] base, wa;
  logic [1:0]    cnt;
  logic [DW-1:0] od;

  function automatic logic [AW-1:0] word_at(input logic [AW-1:0] b, input logic [1:0] c, input logic xo);
    return {b[AW-1:2], xo ? (b[1:0] ^ c) : (b[1:0] + c)};
  endfunction

  wire cpu_go = !ads_cpu_n && !cs1_n;
  wire go     = cpu_go || !ads_ctl_n;
  wire sel    = !cs1_n && cs2 && !cs3_n;
  wire [LANES-1:0] lanes = !gw_n ? '1 : (bwe_n ? '0 : ~bw_n);
  wire wr     = |lanes;

  logic          n_act, n_rd;
  logic [AW-1:0] n_base;
  logic [1:0]    n_cnt;

  always_comb begin
    n_act  = act;
    n_base = base;
    n_cnt  = cnt;
    n_rd   = !wr;
    if (go) begin
      n_act = sel;
      n_rd  = cpu_go || !wr;
      if (sel) begin
        n_base = addr;
        n_cnt  = 2'd0;
      end
    end else if (act && !adv_n) begin
      n_cnt = cnt + 2'd1;
    end
  end

  wire [AW-1:0] cur   = word_at(base, cnt, interleave);
  wire [AW-1:0] nxt   = word_at(n_base, n_cnt, interleave);
  wire          beat  = act && rd;
  wire [DW-1:0] cur_q = mem[cur];

  wire          w_go   = pipe_mode ? wp : (n_act && !n_rd);
  wire [AW-1:0] w_addr = pipe_mode ? wa : nxt;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (w_go && lanes[i]) mem[w_addr][8*i +: 8] <= wdata[8*i +: 8];
  end

  wire dsel = go && !sel;
  wire keep = dsel && hold_mode && !cs1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      rd   <= 1'b1;
      base <= '0;
      cnt  <= 2'd0;
      ov   <= 1'b0;
      od   <= '0;
      wp   <= 1'b0;
      wa   <= '0;
    end else begin
      act  <= n_act;
      rd   <= n_rd;
      base <= n_base;
      cnt  <= n_cnt;
      ov   <= pipe_mode ? (beat && !(dsel && !keep)) : (beat && keep);
      od   <= cur_q;
      wp   <= pipe_mode && n_act && !n_rd;
      wa   <= nxt;
    end
  end

  wire valid = pipe_mode ? ov : (beat || ov);
  assign dq_o  = (pipe_mode || !beat) ? od : cur_q;
  assign dq_en = valid && !oe_n;
endmodule

module sburst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic pipe_mode,
  input logic cs1_n,
  input logic cs2,
  input logic cs3_n,
  input logic ads_cpu_n,
  input logic ads_ctl_n,
  input logic gw_n,
  input logic oe_n,
  input logic dq_en
);
  // R2
  ctl_desel_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_ctl_n && cs1_n) |=> !dq_en);

  // R11
  stay_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_ctl_n && cs1_n) ##1 (ads_ctl_n && (ads_cpu_n || cs1_n)) |=> !dq_en);

  // R4
  ctl_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !ads_ctl_n && ads_cpu_n && !cs1_n && cs2 && !cs3_n && !gw_n) |=> !dq_en);

  // R3
  cpu_read_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !ads_cpu_n && !cs1_n && cs2 && !cs3_n) |=> (oe_n || dq_en));

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en);
endmodule

bind sburst_sram sburst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs1_n(cs1_n), .cs2(cs2),
  .cs3_n(cs3_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .gw_n(gw_n),
  .oe_n(oe_n), .dq_en(dq_en)
);

// File: tb/sburst_sram_tb.sv
`timescale 1ns/1ps
module sburst_sram_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, pipe_mode = 1'b0, interleave = 1'b1, hold_mode = 1'b0;
  logic cs1_n, cs2, cs3_n, ads_cpu_n, ads_ctl_n, adv_n, gw_n, bwe_n, oe_n;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [31:0] wdata, dq_o;
  logic dq_en;

  sburst_sram #(.AW(AW), .LANES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .interleave(interleave),
    .hold_mode(hold_mode), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .dq_o(dq_o), .dq_en(dq_en)
  );

  int checks = 0, errors = 0;

  // reference model
  logic [31:0] rmem [DEPTH];
  bit m_act, m_rd, m_ov, m_wp, e_val;
  int m_base, m_cnt, m_wa;
  logic [31:0] e_dat;

  function automatic logic [31:0] ival(int a);
    return 32'hC0DE_0000 | a;
  endfunction

  function automatic int word_of(int b, int c);
    int lo;
    lo = interleave ? ((b & 3) ^ c) : (((b & 3) + c) & 3);
    return (b & ~3) | lo;
  endfunction

  task automatic step();
    bit cpu, go, sel, was_beat, writing, desel, holdcase;
    logic [3:0] ln;
    logic [31:0] old;
    int wad, now;
    cpu = !ads_cpu_n && !cs1_n;
    go  = cpu || !ads_ctl_n;
    sel = !cs1_n && cs2 && !cs3_n;
    ln  = !gw_n ? 4'hF : (bwe_n ? 4'h0 : ~bw_n);
    was_beat = m_act && m_rd;
    old = rmem[word_of(m_base, m_cnt)];
    if (go) begin
      m_act = sel;
      if (sel) begin m_base = int'(addr); m_cnt = 0; end
      m_rd = cpu || (ln == 4'h0);
    end else if (m_act) begin
      if (!adv_n) m_cnt = (m_cnt + 1) & 3;
      m_rd = (ln == 4'h0);
    end
    now = word_of(m_base, m_cnt);
    if (pipe_mode) begin
      writing = m_wp; wad = m_wa;
      m_wp = m_act && !m_rd; m_wa = now;
    end else begin
      writing = m_act && !m_rd; wad = now;
    end
    if (writing)
      for (int i = 0; i < 4; i++) if (ln[i]) rmem[wad][8*i +: 8] = wdata[8*i +: 8];
    desel = go && !sel;
    holdcase = desel && hold_mode && !cs1_n;
    if (pipe_mode) begin
      m_ov = was_beat && !(desel && !holdcase);
      e_val = m_ov; e_dat = old;
    end else begin
      m_ov = was_beat && holdcase;
      if (m_act && m_rd) begin e_val = 1; e_dat = rmem[now]; end
      else begin e_val = m_ov; e_dat = old; end
    end
  endtask

  task automatic cyc();
    bit xe;
    @(posedge clk);
    if (rst_n) step();
    else begin m_act = 0; m_rd = 1; m_ov = 0; m_wp = 0; e_val = 0; m_cnt = 0; end
    @(negedge clk);
    xe = e_val && !oe_n;
    checks++;
    if (dq_en !== xe) begin
      errors++;
      $display("FAIL R9 model: dq_en=%b expected %b at %0t", dq_en, xe, $time);
    end else if (xe && dq_o !== e_dat) begin
      errors++;
      $display("FAIL R7 model: dq_o=%h expected %h at %0t", dq_o, e_dat, $time);
    end
  endtask

  task automatic expect_out(string tag, logic en, logic [31:0] d);
    checks++;
    if (dq_en !== en || (en && dq_o !== d)) begin
      errors++;
      $display("FAIL %s: dq_en=%b dq_o=%h expected dq_en=%b dq_o=%h", tag, dq_en, dq_o, en, d);
    end
  endtask

  task automatic idle();
    cs1_n = 0; cs2 = 1; cs3_n = 0; ads_cpu_n = 1; ads_ctl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; wdata = '0;
  endtask

  task automatic do_reset(bit p, bit il, bit h);
    idle();
    rst_n = 0; pipe_mode = p; interleave = il; hold_mode = h;
    repeat (2) cyc();
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R12 watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(0, 1, 0);
    // r12_ reset state
    expect_out("R12 reset", 0, '0);
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ads_ctl_n = 0; addr = AW'(a); gw_n = 0; wdata = ival(a); cyc();
    end

    // R3 processor start reads even with write controls active (R7 flow timing)
    idle(); ads_cpu_n = 0; addr = 6'd5; gw_n = 0; cyc();
    expect_out("R3 cpu start read", 1, ival(5));
    idle(); adv_n = 0; cyc(); expect_out("R5 xor step1", 1, ival(4));
    cyc(); expect_out("R5 xor step2", 1, ival(7));
    cyc(); expect_out("R5 xor step3", 1, ival(6));
    adv_n = 1; cyc(); expect_out("R5 repeat", 1, ival(6));
    gw_n = 0; wdata = 32'h5555_AAAA; cyc(); expect_out("R3 follow-on write quiet", 0, '0);
    gw_n = 1; cyc(); expect_out("R3 follow-on write data", 1, 32'h5555_AAAA);

    // R4 / R6 lane writes
    idle(); ads_ctl_n = 0; addr = 6'd9; bwe_n = 0; bw_n = 4'b1010; wdata = 32'h1122_3344; cyc();
    expect_out("R4 ctl write quiet", 0, '0);
    idle(); ads_ctl_n = 0; addr = 6'd9; bwe_n = 0; bw_n = 4'hF; cyc();
    expect_out("R6 lane merge", 1, 32'hC022_0044);
    idle(); bw_n = 4'h0; cyc();
    expect_out("R6 bwe high reads", 1, 32'hC022_0044);

    // R2 / R1 / R11
    idle(); adv_n = 0; cs1_n = 1; ads_cpu_n = 0; cyc();
    expect_out("R2 cpu strobe ignored", 1, ival(8));
    idle(); adv_n = 0; cs2 = 0; cs3_n = 1; cyc();
    expect_out("R1 enables ignored off start", 1, ival(11));
    idle(); cs1_n = 1; ads_ctl_n = 0; cyc();
    expect_out("R2 ctl deselect", 0, '0);
    idle(); adv_n = 0; gw_n = 0; cyc(); expect_out("R11 adv ignored", 0, '0);
    cyc(); expect_out("R11 adv ignored again", 0, '0);
    idle(); ads_cpu_n = 0; cs2 = 0; addr = 6'd3; cyc();
    expect_out("R1 cs2 low deselects", 0, '0);
    idle(); ads_cpu_n = 0; addr = 6'd3; cyc();
    expect_out("R1 selected start", 1, ival(3));
    oe_n = 1; #0.5; expect_out("R9 oe high", 0, '0);
    oe_n = 0; #0.5; expect_out("R9 oe low", 1, ival(3));

    // linear order and hold in flow-through
    do_reset(0, 0, 1);
    idle(); ads_cpu_n = 0; addr = 6'd13; cyc();
    idle(); adv_n = 0; cyc(); expect_out("R5 linear 1", 1, ival(14));
    cyc(); expect_out("R5 linear 2", 1, ival(15));
    cyc(); expect_out("R5 linear wrap", 1, ival(12));
    idle(); ads_ctl_n = 0; cs3_n = 1; cyc(); expect_out("R10 hold beat", 1, ival(12));
    idle(); cyc(); expect_out("R10 hold ends", 0, '0);

    // pipelined latency, drop, late lanes
    do_reset(1, 1, 0);
    idle(); ads_cpu_n = 0; addr = 6'd3; cyc(); expect_out("R7 pipe first edge", 0, '0);
    idle(); cyc(); expect_out("R7 pipe data", 1, ival(3));
    idle(); adv_n = 0; cyc(); expect_out("R7 pipe repeat", 1, ival(3));
    idle(); ads_ctl_n = 0; cs3_n = 1; cyc(); expect_out("R10 drop no hold", 0, '0);
    idle(); ads_ctl_n = 0; addr = 6'd20; bwe_n = 0; bw_n = 4'b1110; wdata = 32'hAAAA_AAAA; cyc();
    idle(); bwe_n = 0; bw_n = 4'b0111; wdata = 32'hDEAD_BEEF; cyc();
    idle(); cyc();
    idle(); cyc(); expect_out("R8 late lanes", 1, 32'hDEDE_0014);

    // random phase under every strap combination
    for (int s = 0; s < 8; s++) begin
      do_reset(s[0], s[1], s[2]);
      for (int n = 0; n < 600; n++) begin
        ads_cpu_n = ($urandom % 7) != 0;
        ads_ctl_n = ($urandom % 7) != 0;
        cs1_n = ($urandom % 5) == 0;
        cs2   = ($urandom % 7) != 0;
        cs3_n = ($urandom % 7) == 0;
        adv_n = $urandom % 2;
        gw_n  = ($urandom % 10) != 0;
        bwe_n = ($urandom % 5) > 1;
        bw_n  = 4'($urandom);
        oe_n  = ($urandom % 5) == 0;
        addr  = AW'($urandom);
        wdata = $urandom;
        cyc();
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule